// File: doc/BRIEF.md
# Serial Flash Erase Command Responder

This block is the device side of a serial flash command interface, reduced to what erasing needs. A host drives an active-low chip select, a serial clock and a data input. The block moves each bit in on the rising serial clock edge, most significant bit first, and assembles bytes. It keeps two status bits: a write-enable latch and a write-in-progress flag. It recognises four opcodes. 06h arms the latch. 05h returns the status byte on the data output. C7h requests a whole-array erase. D8h, followed by a 24-bit address, requests an erase of the sector that holds that address.

An erase does not start when its opcode is decoded. It starts when chip select rises after a complete, correctly framed erase command. The latch must be armed and no earlier erase may still be running. At that point the block issues a one-cycle erase request, with a whole-array flag and a sector number taken from the upper address bits. It clears the latch and holds write-in-progress for a fixed number of system clocks. Durations are set separately for bulk and sector erases. The storage array that performs the erase (each affected byte reading FFh afterwards) sits outside this block. Serial inputs are sampled on the system clock and must already be synchronous to it. Each serial clock phase must last at least two system clocks.

Top module: `flash_erase_responder`

## Requirements
- R1: After reset the status byte reads 00h, erase_req_o is 0 and sdo_o is 0.
- R2: Opcode 06h, sent alone and closed by chip select rising on a byte boundary, sets the write-enable latch (status bit 1).
- R3: After opcode 05h, sdo_o returns the status byte most significant bit first. Bit 0 is write-in-progress, bit 1 is the write-enable latch, and bits 7..2 are 0. Each bit changes after a falling serial clock edge and is valid on the next rising edge. The byte repeats while chip select stays low.
- R4: Opcode D8h followed by a 24-bit address, sent MSB first and closed by chip select rising, produces a single-cycle erase_req_o pulse. With it come erase_bulk_o = 0 and erase_sector_o = address bits 23..16. Any address inside a sector selects the same sector.
- R5: Opcode C7h, sent alone and closed by chip select rising, produces an erase_req_o pulse with erase_bulk_o = 1.
- R6: An erase command received while the write-enable latch is 0 is ignored.
- R7: When an erase starts, the write-enable latch clears. Write-in-progress is then 1 for SECT_CYC (sector) or BULK_CYC (bulk) system clocks and afterwards returns to 0.
- R8: Erase commands that close while write-in-progress is 1 are ignored. Status reads and 06h remain effective during that time.
- R9: A command is dropped if chip select rises between byte boundaries, before the full address has arrived, or after extra bytes beyond the command.
- R10: Opcodes other than 06h, 05h, C7h and D8h change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Active-low chip select |
| sclk_i | input | 1 | Serial clock, sampled on clk_i |
| sdi_i | input | 1 | Serial data in, taken on rising sclk_i |
| sdo_o | output | 1 | Serial status data out |
| erase_req_o | output | 1 | One-cycle erase request pulse |
| erase_bulk_o | output | 1 | Request covers the whole array |
| erase_sector_o | output | ADDR_W-SECT_LSB | Sector number of the request |

## Verification
The assertions check several properties on every cycle. An erase request lasts exactly one cycle. A new erase never starts while one is running. Write-in-progress drops exactly when the duration counter runs out. The latch is already clear whenever write-in-progress rises. The sector output stays stable during an erase. The bit counter sits at zero whenever chip select was high. Some behaviour depends on whole command sequences and only the bench scenarios can show it: which framings are dropped, the gating by the latch, the serial status byte as the host sees it, and the sector chosen from different addresses.

// File: rtl/fer_pkg.sv
package fer_pkg;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_BULK = 8'hC7;
  localparam logic [7:0] OP_SECT = 8'hD8;

  typedef enum logic [2:0] {
    ST_OPC, ST_ADDR, ST_WREN, ST_ERASE, ST_RDSR, ST_DROP
  } cmd_st_e;
endpackage

// File: rtl/fer_rx.sv
module fer_rx (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_ni,
  input  logic       sclk_i,
  input  logic       sdi_i,
  output logic       sclk_rise_o,
  output logic       sclk_fall_o,
  output logic       cs_rise_o,
  output logic       boundary_o,
  output logic       byte_vld_o,
  output logic [7:0] byte_o
);
  logic       sclk_q, cs_q;
  logic [2:0] bit_cnt;

  assign sclk_rise_o = sclk_i & ~sclk_q & ~cs_ni;
  assign sclk_fall_o = ~sclk_i & sclk_q & ~cs_ni;
  assign cs_rise_o   = cs_ni & ~cs_q;
  assign boundary_o  = (bit_cnt == 3'd0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q     <= 1'b0;
      cs_q       <= 1'b1;
      bit_cnt    <= '0;
      byte_o     <= '0;
      byte_vld_o <= 1'b0;
    end else begin
      sclk_q     <= sclk_i;
      cs_q       <= cs_ni;
      byte_vld_o <= 1'b0;
      if (cs_ni) begin
        bit_cnt <= '0;
      end else if (sclk_rise_o) begin
        byte_o  <= {byte_o[6:0], sdi_i};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) byte_vld_o <= 1'b1;
      end
    end
  end

  // R9: framing restarts at every deselect
  a_r9_cnt_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_q |-> bit_cnt == 3'd0);
endmodule

// File: rtl/fer_cmd.sv
module fer_cmd
  import fer_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int SECT_LSB = 16,
  localparam int SECT_W  = ADDR_W - SECT_LSB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_vld_i,
  input  logic [7:0]        byte_i,
  input  logic              cs_rise_i,
  input  logic              boundary_i,
  input  logic              busy_i,
  output logic              start_o,
  output logic              bulk_o,
  output logic [SECT_W-1:0] sector_o,
  output logic              wel_o,
  output logic              rd_load_o,
  output logic              rd_active_o
);
  localparam int ADDR_BYTES = ADDR_W / 8;

  cmd_st_e           st;
  logic [1:0]        addr_cnt;
  logic [ADDR_W-1:0] addr;
  logic              is_bulk;

  assign rd_load_o   = byte_vld_i & ~cs_rise_i & (st == ST_OPC) & (byte_i == OP_RDSR);
  assign rd_active_o = (st == ST_RDSR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st       <= ST_OPC;
      addr_cnt <= '0;
      addr     <= '0;
      is_bulk  <= 1'b0;
      start_o  <= 1'b0;
      bulk_o   <= 1'b0;
      sector_o <= '0;
      wel_o    <= 1'b0;
    end else begin
      start_o <= 1'b0;
      if (cs_rise_i) begin
        if (boundary_i) begin
          case (st)
            ST_WREN:  wel_o <= 1'b1;
            ST_ERASE: if (wel_o && !busy_i) begin
              start_o  <= 1'b1;
              wel_o    <= 1'b0;
              bulk_o   <= is_bulk;
              sector_o <= is_bulk ? '0 : addr[ADDR_W-1:SECT_LSB];
            end
            default: ;
          endcase
        end
        st       <= ST_OPC;
        addr_cnt <= '0;
      end else if (byte_vld_i) begin
        case (st)
          ST_OPC: begin
            case (byte_i)
              OP_WREN: st <= ST_WREN;
              OP_RDSR: st <= ST_RDSR;
              OP_BULK: begin st <= ST_ERASE; is_bulk <= 1'b1; end
              OP_SECT: begin st <= ST_ADDR;  is_bulk <= 1'b0; end
              default: st <= ST_DROP;
            endcase
          end
          ST_ADDR: begin
            addr     <= {addr[ADDR_W-9:0], byte_i};
            addr_cnt <= addr_cnt + 2'd1;
            if (addr_cnt == 2'(ADDR_BYTES - 1)) st <= ST_ERASE;
          end
          ST_RDSR, ST_DROP: ;
          default: st <= ST_DROP;  // trailing bytes void the command
        endcase
      end
    end
  end

  // R8: no erase launched over a running one
  a_r8_start_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> !busy_i);
endmodule

// File: rtl/fer_timer.sv
module fer_timer #(
  parameter int SECT_CYC = 2000,
  parameter int BULK_CYC = 6000,
  localparam int MAX_CYC = (BULK_CYC > SECT_CYC) ? BULK_CYC : SECT_CYC,
  localparam int CNT_W   = $clog2(MAX_CYC)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic bulk_i,
  output logic busy_o
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt    <= '0;
      busy_o <= 1'b0;
    end else if (start_i) begin
      cnt    <= bulk_i ? CNT_W'(BULK_CYC - 1) : CNT_W'(SECT_CYC - 1);
      busy_o <= 1'b1;
    end else if (busy_o) begin
      if (cnt == '0) busy_o <= 1'b0;
      else           cnt    <= cnt - 1'b1;
    end
  end

  a_r7_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o);
  a_r7_expire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && cnt == '0 && !start_i |=> !busy_o);
endmodule

// File: rtl/fer_sdo.sv
module fer_sdo (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sclk_rise_i,
  input  logic       sclk_fall_i,
  input  logic       load_i,
  input  logic       active_i,
  input  logic [7:0] status_i,
  output logic       sdo_o
);
  logic [7:0] sr;
  logic [2:0] cnt;
  logic       armed;  // host has taken the current bit

  assign sdo_o = active_i & sr[7];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr    <= '0;
      cnt   <= '0;
      armed <= 1'b0;
    end else if (load_i) begin
      sr    <= status_i;
      cnt   <= '0;
      armed <= 1'b0;
    end else if (active_i) begin
      if (sclk_rise_i) begin
        armed <= 1'b1;
      end else if (sclk_fall_i && armed) begin
        armed <= 1'b0;
        cnt   <= cnt + 3'd1;
        sr    <= (cnt == 3'd7) ? status_i : {sr[6:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/flash_erase_responder.sv
module flash_erase_responder #(
  parameter int ADDR_W   = 24,
  parameter int SECT_LSB = 16,
  parameter int SECT_CYC = 2000,
  parameter int BULK_CYC = 6000,
  localparam int SECT_W  = ADDR_W - SECT_LSB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              erase_req_o,
  output logic              erase_bulk_o,
  output logic [SECT_W-1:0] erase_sector_o
);
  logic       sclk_rise, sclk_fall, cs_rise, boundary, byte_vld;
  logic [7:0] rx_byte;
  logic       wel, wip, rd_load, rd_active;

  fer_rx u_rx (
    .clk_i, .rst_ni, .cs_ni, .sclk_i, .sdi_i,
    .sclk_rise_o(sclk_rise), .sclk_fall_o(sclk_fall), .cs_rise_o(cs_rise),
    .boundary_o(boundary), .byte_vld_o(byte_vld), .byte_o(rx_byte)
  );

  fer_cmd #(.ADDR_W(ADDR_W), .SECT_LSB(SECT_LSB)) u_cmd (
    .clk_i, .rst_ni, .byte_vld_i(byte_vld), .byte_i(rx_byte),
    .cs_rise_i(cs_rise), .boundary_i(boundary), .busy_i(wip),
    .start_o(erase_req_o), .bulk_o(erase_bulk_o), .sector_o(erase_sector_o),
    .wel_o(wel), .rd_load_o(rd_load), .rd_active_o(rd_active)
  );

  fer_timer #(.SECT_CYC(SECT_CYC), .BULK_CYC(BULK_CYC)) u_timer (
    .clk_i, .rst_ni, .start_i(erase_req_o), .bulk_i(erase_bulk_o), .busy_o(wip)
  );

  fer_sdo u_sdo (
    .clk_i, .rst_ni, .sclk_rise_i(sclk_rise), .sclk_fall_i(sclk_fall),
    .load_i(rd_load), .active_i(rd_active),
    .status_i({6'b0, wel, wip}), .sdo_o
  );

  a_r4_req_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_req_o |=> !erase_req_o);
  a_r4_sector_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wip && !erase_req_o |=> $stable(erase_sector_o) && $stable(erase_bulk_o));
  a_r7_wel_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wip) |-> !wel);
endmodule

// File: tb/flash_erase_responder_tb.sv
module flash_erase_responder_tb;
  localparam int SECT_CYC = 200;
  localparam int BULK_CYC = 500;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic sdo, req, bulk;
  logic [7:0] sector;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 1'b0;

  // reference model state
  bit    m_wel = 1'b0;
  int    m_req_cyc = -1, m_wip_end = 0;
  bit    m_bulk = 1'b0;
  int    m_sector = 0;
  string m_tag = "R1";

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  flash_erase_responder #(.SECT_CYC(SECT_CYC), .BULK_CYC(BULK_CYC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .sdi_i(sdi),
    .sdo_o(sdo), .erase_req_o(req), .erase_bulk_o(bulk), .erase_sector_o(sector)
  );

  // per-clock comparison of the request outputs
  always @(negedge clk) if (rst_n && !done) begin
    checks++;
    if (req !== (cyc == m_req_cyc)) begin
      fails++;
      $display("FAIL %s: erase_req_o=%0b expected %0b at cycle %0d", m_tag, req, cyc == m_req_cyc, cyc);
    end else if (req && (bulk !== m_bulk || (!m_bulk && sector !== m_sector[7:0]))) begin
      fails++;
      $display("FAIL %s: bulk=%0b sector=%02h expected bulk=%0b sector=%02h", m_tag, bulk, sector, m_bulk, m_sector[7:0]);
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sclk = 1'b0; sdi = v[i]; wait_n(2);
      sclk = 1'b1; wait_n(2);
    end
    sclk = 1'b0; wait_n(2);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  // full command with optional address bytes and stray bits, closed by deselect
  task automatic run_cmd(input logic [7:0] op, input logic [23:0] addr,
                         input int abytes, input int extra, input string tag);
    bit whole, wip_now;
    m_tag = tag;
    cs_n = 1'b0; wait_n(2);
    send_bits({24'h0, op}, 8);
    if (abytes > 0) send_bits({8'h0, addr} >> (8 * (3 - abytes)), 8 * abytes);
    if (extra > 0) send_bits(32'h0, extra);
    whole   = ((op == 8'hD8) ? (abytes == 3) : (abytes == 0)) && extra == 0;
    wip_now = cyc < m_wip_end;
    if (whole && op == 8'h06) m_wel = 1'b1;
    if (whole && (op == 8'hC7 || op == 8'hD8) && m_wel && !wip_now) begin
      m_req_cyc = cyc + 1;
      m_bulk    = (op == 8'hC7);
      m_sector  = int'(addr[23:16]);
      m_wel     = 1'b0;
      m_wip_end = m_req_cyc + (m_bulk ? BULK_CYC : SECT_CYC) + 1;
    end
    cs_n = 1'b1; wait_n(4);
  endtask

  task automatic read_status(input string tag, input int nbytes);
    logic [7:0] b;
    int exp;
    m_tag = tag;
    exp = {30'h0, m_wel, cyc < m_wip_end};
    cs_n = 1'b0; wait_n(2);
    send_bits(32'h05, 8);
    for (int k = 0; k < nbytes; k++) begin
      for (int i = 7; i >= 0; i--) begin
        sclk = 1'b0; wait_n(2);
        b[i] = sdo;
        sclk = 1'b1; wait_n(2);
      end
      check(tag, int'(b), exp);
    end
    sclk = 1'b0; wait_n(2);
    cs_n = 1'b1; wait_n(4);
  endtask

  task automatic wait_idle();
    while (cyc < m_wip_end + 5) wait_n(1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    finish_run();
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);
    // R1 reset state
    check("R1 req", int'(req), 0);
    check("R1 sdo", int'(sdo), 0);
    read_status("R1 status", 1);

    // R6 erase without latch
    run_cmd(8'hD8, 24'h12ABCD, 3, 0, "R6 sector no wel");
    run_cmd(8'hC7, 24'h0, 0, 0, "R6 bulk no wel");
    read_status("R6 status", 1);

    // R10 unknown opcode, R2 arm latch, R3 repeated status
    run_cmd(8'h9F, 24'h0, 0, 0, "R10 unknown");
    read_status("R10 status", 1);
    run_cmd(8'h06, 24'h0, 0, 0, "R2 wren");
    read_status("R3 status repeat", 2);

    // R9 framing faults keep latch, start nothing
    run_cmd(8'hD8, 24'h120000, 2, 0, "R9 short address");
    run_cmd(8'hC7, 24'h0, 0, 3, "R9 mid-byte deselect");
    run_cmd(8'hC7, 24'h0, 0, 8, "R9 extra byte");
    run_cmd(8'h06, 24'h0, 0, 5, "R9 partial wren");
    read_status("R9 status", 1);

    // R4 sector erase, R7 status during and after
    run_cmd(8'hD8, 24'h12ABCD, 3, 0, "R4 sector 12");
    read_status("R7 sector busy", 1);
    // R8 erase during busy ignored, latch may re-arm
    run_cmd(8'h06, 24'h0, 0, 0, "R8 wren busy");
    run_cmd(8'hC7, 24'h0, 0, 0, "R8 bulk busy");
    read_status("R8 status busy", 1);
    wait_idle();
    read_status("R7 sector done", 1);

    // R4 another address within same sector, latch still armed
    run_cmd(8'hD8, 24'h12FFFF, 3, 0, "R4 sector 12 top");
    wait_idle();
    run_cmd(8'h06, 24'h0, 0, 0, "R2 wren again");
    run_cmd(8'hD8, 24'hA50001, 3, 0, "R4 sector A5");
    wait_idle();

    // R5 bulk erase, R7 bulk duration
    run_cmd(8'h06, 24'h0, 0, 0, "R2 wren bulk");
    run_cmd(8'hC7, 24'h0, 0, 0, "R5 bulk");
    wait_n(SECT_CYC + 20);
    read_status("R7 bulk still busy", 1);
    wait_idle();
    read_status("R7 bulk done", 1);
    check("R1 sdo idle", int'(sdo), 0);

    wait_n(5);
    finish_run();
  end
endmodule